// File: doc/BRIEF.md
# Accumulator ALU with Selective Status Flags

This block is the 8-bit execute stage of a small accumulator machine. Each cycle that `in_valid` is high it takes the working-register value, a file-register value, an 8-bit literal, the current carry bit, an operation code and a few operand fields. It computes one result byte, the new Carry, Digit Carry and Zero flags, and a separate write enable for each flag. It also issues two destination strobes, one that writes the working register and one that writes the file register back. All of these leave the block through one register stage, so they are valid on the clock edge after the request.

Each operation updates only its own set of flags. The surrounding datapath writes a flag back only when that flag's enable is high, and keeps its old value otherwise. Subtraction reports carry as an inverted borrow. Rotates shift through the carry bit. Instruction fetch, decode, the register file and the program counter lie outside the block.

Top module: `alu_acc_core`

## Requirements
- R1: ADD (op 1) outputs operand2 + W modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero. All three flag enables are high.
- R2: SUB (op 2) outputs operand2 − W modulo 256. C is 1 when operand2 ≥ W. DC is 1 when the low nibble of operand2 ≥ the low nibble of W. Z marks a zero result. All three flag enables are high. Example: 0x03 − 0x04 gives 0xFF with C=0 and Z=0.
- R3: AND (3), IOR (4), XOR (5), complement of f (6), increment of f (7), decrement of f (8) and move-f (13) raise only the Z enable. Z equals (result == 0). Increment of 0xFF gives 0x00, and decrement of 0x01 gives 0x00, both with Z=1.
- R4: Rotate-left (9) outputs {f[6:0], carry_i} and C=f[7]. Rotate-right (10) outputs {carry_i, f[7:1]} and C=f[0]. Only the C enable is high.
- R5: Nibble swap (11) outputs {f[3:0], f[7:4]}, for example 0xF3 becomes 0x3F, and raises no flag enable.
- R6: For ops 1–13, `dest_f_i`=0 raises `w_we_o` and `dest_f_i`=1 raises `f_we_o`. For ops 1–5, `src_lit_i`=1 selects the literal as operand2 and always writes W. Otherwise operand2 is `f_i`. Op 14 writes W into f with no flag. At most one destination strobe is high at a time.
- R7: Clear (12) outputs 0x00 with Z=1, and only the Z enable is high.
- R8: Bit-set (15) and bit-clear (16) output `f_i` with the one bit chosen by `bit_idx_i` forced to 1 or 0. They raise `f_we_o` and no flag enable.
- R9: Load-constant (0) outputs `lit_i`, raises `w_we_o` and raises no flag enable.
- R10: Results, flags and enables for a request with `in_valid` high appear with `out_valid_o` high exactly one clock edge later. Synchronous reset clears `out_valid_o` and every enable.
- R11: A cycle with `in_valid` low produces `out_valid_o` low and all five enables low on the following edge.
- R12: Op codes 17–31 produce `out_valid_o` high with all five enables low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_i | input | 5 | Operation code |
| src_lit_i | input | 1 | Use literal as operand2 for ops 1–5 |
| dest_f_i | input | 1 | 0 writes W, 1 writes f |
| bit_idx_i | input | 3 | Bit index for bit-set and bit-clear |
| w_i | input | 8 | Working register value |
| f_i | input | 8 | File register value |
| lit_i | input | 8 | Literal value |
| carry_i | input | 1 | Current carry flag |
| out_valid_o | output | 1 | Result present |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | New carry |
| dc_o | output | 1 | New digit carry |
| z_o | output | 1 | New zero flag |
| c_we_o | output | 1 | Carry write enable |
| dc_we_o | output | 1 | Digit carry write enable |
| z_we_o | output | 1 | Zero write enable |
| w_we_o | output | 1 | Working register write strobe |
| f_we_o | output | 1 | File register write strobe |

## Verification
The hardest case to reach is the digit carry of subtraction. Its value depends only on the low nibbles, so it takes a borrow that appears in the low nibble but not in the full byte, or the reverse. Random bytes seldom isolate those cases. The stimulus therefore sweeps every pair of W and operand bytes once. It spreads the op code, literal selection, destination and carry across the sweep with cheap arithmetic on the pair indices, so every op sees every nibble relationship. Directed vectors then pin the named boundary examples.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW_DEF = 8;
  localparam int OPW    = 5;

  typedef enum logic [OPW-1:0] {
    OP_LDK = 5'd0,  OP_ADD = 5'd1,  OP_SUB = 5'd2,  OP_AND = 5'd3,
    OP_IOR = 5'd4,  OP_XOR = 5'd5,  OP_CPL = 5'd6,  OP_INC = 5'd7,
    OP_DEC = 5'd8,  OP_ROL = 5'd9,  OP_ROR = 5'd10, OP_SWP = 5'd11,
    OP_CLR = 5'd12, OP_MVF = 5'd13, OP_MWF = 5'd14, OP_BST = 5'd15,
    OP_BCL = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_t;

  function automatic logic takes_literal(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_IOR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu_pkg::*;
#(
  parameter int DW = DW_DEF
) (
  input  alu_op_e       op,
  input  logic          src_lit,
  input  logic [DW-1:0] f_val,
  input  logic [DW-1:0] lit_val,
  output logic [DW-1:0] opnd,
  output logic          lit_form
);
  always_comb begin
    lit_form = src_lit && takes_literal(op);
    opnd     = lit_form ? lit_val : f_val;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] opnd,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          dc_out
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] addend;
  logic [DW:0]   full;
  logic [HALF:0] low;

  // subtraction: opnd + ~w + 1, so carry out means "no borrow"
  always_comb begin
    addend = sub ? ~w_val : w_val;
    full   = {1'b0, opnd} + {1'b0, addend} + {{DW{1'b0}}, sub};
    low    = {1'b0, opnd[HALF-1:0]} + {1'b0, addend[HALF-1:0]} + {{HALF{1'b0}}, sub};
    sum    = full[DW-1:0];
    c_out  = full[DW];
    dc_out = low[HALF];
  end
endmodule

// File: rtl/alu_bitlogic.sv
module alu_bitlogic
  import alu_pkg::*;
#(
  parameter int DW = DW_DEF,
  localparam int IW = $clog2(DW)
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] swapped;
  logic [DW-1:0] sel_mask;

  genvar gi;
  generate
    for (gi = 0; gi < HALF; gi++) begin : g_swap
      assign swapped[gi]        = opnd[gi + HALF];
      assign swapped[gi + HALF] = opnd[gi];
    end
    for (gi = 0; gi < DW; gi++) begin : g_mask
      assign sel_mask[gi] = (idx == IW'(gi));
    end
  endgenerate

  always_comb begin
    res  = opnd;
    cout = cin;
    case (op)
      OP_AND: res = w_val & opnd;
      OP_IOR: res = w_val | opnd;
      OP_XOR: res = w_val ^ opnd;
      OP_CPL: res = ~opnd;
      OP_INC: res = opnd + 1'b1;
      OP_DEC: res = opnd - 1'b1;
      OP_ROL: begin
        res  = {opnd[DW-2:0], cin};
        cout = opnd[DW-1];
      end
      OP_ROR: begin
        res  = {cin, opnd[DW-1:1]};
        cout = opnd[0];
      end
      OP_SWP: res = swapped;
      OP_BST: res = opnd | sel_mask;
      OP_BCL: res = opnd & ~sel_mask;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/alu_acc_core.sv
module alu_acc_core
  import alu_pkg::*;
#(
  parameter int DW = DW_DEF,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    op_i,
  input  logic          src_lit_i,
  input  logic          dest_f_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] lit_i,
  input  logic          carry_i,
  output logic          out_valid_o,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o,
  output logic          c_we_o,
  output logic          dc_we_o,
  output logic          z_we_o,
  output logic          w_we_o,
  output logic          f_we_o
);
  alu_op_e       op;
  logic [DW-1:0] opnd;
  logic          lit_form;
  logic [DW-1:0] as_sum;
  logic          as_c, as_dc;
  logic [DW-1:0] bl_res;
  logic          bl_c;

  logic [DW-1:0] nx_res;
  flag_t         nx_flag, nx_we;
  logic          nx_w_we, nx_f_we;

  assign op = alu_op_e'(op_i);

  alu_opnd_sel #(.DW(DW)) u_sel (
    .op(op), .src_lit(src_lit_i), .f_val(f_i), .lit_val(lit_i),
    .opnd(opnd), .lit_form(lit_form)
  );

  alu_addsub #(.DW(DW)) u_addsub (
    .w_val(w_i), .opnd(opnd), .sub(op == OP_SUB),
    .sum(as_sum), .c_out(as_c), .dc_out(as_dc)
  );

  alu_bitlogic #(.DW(DW)) u_bitlogic (
    .op(op), .w_val(w_i), .opnd(opnd), .cin(carry_i), .idx(bit_idx_i),
    .res(bl_res), .cout(bl_c)
  );

  // decode: result source, flag enables, destination strobe
  always_comb begin
    logic to_dest;
    nx_res   = bl_res;
    nx_flag  = '{c: bl_c, dc: as_dc, z: 1'b0};
    nx_we    = '0;
    nx_w_we  = 1'b0;
    nx_f_we  = 1'b0;
    to_dest  = 1'b0;
    case (op)
      OP_LDK: begin
        nx_res  = lit_i;
        nx_w_we = 1'b1;
      end
      OP_ADD, OP_SUB: begin
        nx_res    = as_sum;
        nx_flag.c = as_c;
        nx_we     = '{c: 1'b1, dc: 1'b1, z: 1'b1};
        to_dest   = 1'b1;
      end
      OP_AND, OP_IOR, OP_XOR, OP_CPL, OP_INC, OP_DEC, OP_MVF: begin
        nx_we.z = 1'b1;
        to_dest = 1'b1;
      end
      OP_ROL, OP_ROR: begin
        nx_we.c = 1'b1;
        to_dest = 1'b1;
      end
      OP_SWP: to_dest = 1'b1;
      OP_CLR: begin
        nx_res  = '0;
        nx_we.z = 1'b1;
        to_dest = 1'b1;
      end
      OP_MWF: begin
        nx_res  = w_i;
        nx_f_we = 1'b1;
      end
      OP_BST, OP_BCL: nx_f_we = 1'b1;
      default: ;
    endcase
    if (to_dest) begin
      nx_w_we = lit_form || !dest_f_i;
      nx_f_we = !lit_form && dest_f_i;
    end
    nx_flag.z = (nx_res == '0);
  end

  // control registers carry reset; data registers do not
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      c_we_o      <= 1'b0;
      dc_we_o     <= 1'b0;
      z_we_o      <= 1'b0;
      w_we_o      <= 1'b0;
      f_we_o      <= 1'b0;
    end else begin
      out_valid_o <= in_valid;
      c_we_o      <= in_valid && nx_we.c;
      dc_we_o     <= in_valid && nx_we.dc;
      z_we_o      <= in_valid && nx_we.z;
      w_we_o      <= in_valid && nx_w_we;
      f_we_o      <= in_valid && nx_f_we;
    end
  end

  always_ff @(posedge clk) begin
    res_o <= nx_res;
    c_o   <= nx_flag.c;
    dc_o  <= nx_flag.dc;
    z_o   <= nx_flag.z;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> !(c_we_o || dc_we_o || z_we_o || w_we_o || f_we_o)); // R11
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0({w_we_o, f_we_o})); // R6
  AST_Z_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && z_we_o) |-> (z_o == (res_o == '0))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == OP_CLR) |=> (res_o == '0 && z_o && z_we_o && !c_we_o)); // R7
  AST_SWAP_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == OP_SWP) |=> !(c_we_o || dc_we_o || z_we_o)); // R5
  AST_ROT_C_ONLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_i == OP_ROL || op_i == OP_ROR)) |=> (c_we_o && !dc_we_o && !z_we_o)); // R4
  AST_BIT_TO_F: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_i == OP_BST || op_i == OP_BCL)) |=> (f_we_o && !z_we_o && !c_we_o)); // R8
  AST_LDK_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == OP_LDK) |=> (w_we_o && res_o == $past(lit_i) && !z_we_o)); // R9
  AST_MWF_COPY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == OP_MWF) |=> (f_we_o && res_o == $past(w_i))); // R6
endmodule

// File: tb/alu_acc_core_tb_top.sv
module alu_acc_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [4:0] op_i;
  logic       src_lit_i, dest_f_i, carry_i;
  logic [2:0] bit_idx_i;
  logic [7:0] w_i, f_i, lit_i;
  logic       out_valid_o, c_o, dc_o, z_o;
  logic       c_we_o, dc_we_o, z_we_o, w_we_o, f_we_o;
  logic [7:0] res_o;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [7:0] res;
    logic c, dc, z, cwe, dcwe, zwe, wwe, fwe;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_acc_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
    .src_lit_i(src_lit_i), .dest_f_i(dest_f_i), .bit_idx_i(bit_idx_i),
    .w_i(w_i), .f_i(f_i), .lit_i(lit_i), .carry_i(carry_i),
    .out_valid_o(out_valid_o), .res_o(res_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o),
    .c_we_o(c_we_o), .dc_we_o(dc_we_o), .z_we_o(z_we_o),
    .w_we_o(w_we_o), .f_we_o(f_we_o)
  );

  function automatic string tag_of(int op);
    case (op)
      0: return "R9";
      1: return "R1";
      2: return "R2";
      3, 4, 5, 6, 7, 8, 13: return "R3";
      9, 10: return "R4";
      11: return "R5";
      12: return "R7";
      14: return "R6";
      15, 16: return "R8";
      default: return "R12";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(int op, bit sl, bit df, int idx,
                                 int w, int f, int lit, bit cin);
    exp_t e;
    int   b, r;
    bit   lf, dest;
    e = '{res: 8'h00, c: 0, dc: 0, z: 0, cwe: 0, dcwe: 0, zwe: 0, wwe: 0, fwe: 0, tag: tag_of(op)};
    lf   = sl && (op >= 1 && op <= 5);
    b    = lf ? lit : f;
    r    = 0;
    dest = 1;
    case (op)
      0: begin r = lit; dest = 0; e.wwe = 1; end
      1: begin r = w + b; e.c = (r > 255); e.dc = ((w % 16) + (b % 16)) > 15;
               e.cwe = 1; e.dcwe = 1; e.zwe = 1; end
      2: begin r = b - w + 256; e.c = (b >= w); e.dc = ((b % 16) >= (w % 16));
               e.cwe = 1; e.dcwe = 1; e.zwe = 1; end
      3: begin r = w & b; e.zwe = 1; end
      4: begin r = w | b; e.zwe = 1; end
      5: begin r = w ^ b; e.zwe = 1; end
      6: begin r = 255 - b; e.zwe = 1; end
      7: begin r = b + 1; e.zwe = 1; end
      8: begin r = b + 255; e.zwe = 1; end
      9: begin r = b * 2 + int'(cin); e.c = (b >= 128); e.cwe = 1; end
      10: begin r = b / 2 + (cin ? 128 : 0); e.c = b[0]; e.cwe = 1; end
      11: begin r = (b % 16) * 16 + b / 16; end
      12: begin r = 0; e.zwe = 1; end
      13: begin r = b; e.zwe = 1; end
      14: begin r = w; dest = 0; e.fwe = 1; end
      15: begin r = b | (1 << idx); dest = 0; e.fwe = 1; end
      16: begin r = b & ~(1 << idx); dest = 0; e.fwe = 1; end
      default: dest = 0;
    endcase
    e.res = 8'(r % 256);
    e.z   = (e.res == 8'h00);
    if (dest) begin
      e.wwe = lf || !df;
      e.fwe = !lf && df;
    end
    return e;
  endfunction

  task automatic drive(int op, bit sl, bit df, int idx, int w, int f, int lit, bit cin);
    in_valid  = 1'b1;
    op_i      = 5'(op);
    src_lit_i = sl;
    dest_f_i  = df;
    bit_idx_i = 3'(idx);
    w_i       = 8'(w);
    f_i       = 8'(f);
    lit_i     = 8'(lit);
    carry_i   = cin;
  endtask

  // drive at negedge, expectation from model
  task automatic send(int op, bit sl, bit df, int idx, int w, int f, int lit, bit cin);
    @(negedge clk);
    drive(op, sl, df, idx, w, f, lit, cin);
    sb_q.push_back(model(op, sl, df, idx, w, f, lit, cin));
  endtask

  // drive with a hand-written expectation
  task automatic send_x(int op, bit sl, bit df, int idx, int w, int f, int lit, bit cin, exp_t e);
    @(negedge clk);
    drive(op, sl, df, idx, w, f, lit, cin);
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_i     = 5'd12;
    end
  endtask

  // monitor: pops one expectation per valid output
  always @(negedge clk) begin
    if (!rst && out_valid_o) begin
      exp_t e;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: unexpected output res=%02h expected none", res_o);
      end else begin
        bit bad;
        e   = sb_q.pop_front();
        bad = ({c_we_o, dc_we_o, z_we_o, w_we_o, f_we_o} !== {e.cwe, e.dcwe, e.zwe, e.wwe, e.fwe});
        if ((e.wwe || e.fwe) && res_o !== e.res) bad = 1;
        if (e.cwe && c_o !== e.c) bad = 1;
        if (e.dcwe && dc_o !== e.dc) bad = 1;
        if (e.zwe && z_o !== e.z) bad = 1;
        if (bad) begin
          n_fail++;
          $display("FAIL %s: res=%02h c=%b dc=%b z=%b we=%b%b%b%b%b expected res=%02h c=%b dc=%b z=%b we=%b%b%b%b%b",
                   e.tag, res_o, c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o, w_we_o, f_we_o,
                   e.res, e.c, e.dc, e.z, e.cwe, e.dcwe, e.zwe, e.wwe, e.fwe);
        end
      end
    end
  end

  task automatic check_quiet(string tag);
    n_checks++;
    if (out_valid_o !== 1'b0 || {c_we_o, dc_we_o, z_we_o, w_we_o, f_we_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL %s: valid=%b we=%b%b%b%b%b expected valid=0 we=00000",
               tag, out_valid_o, c_we_o, dc_we_o, z_we_o, w_we_o, f_we_o);
    end
  endtask

  function automatic exp_t mk(int res, bit c, bit dc, bit z, bit cwe, bit dcwe, bit zwe,
                              bit wwe, bit fwe, string tag);
    return '{res: 8'(res), c: c, dc: dc, z: z, cwe: cwe, dcwe: dcwe, zwe: zwe,
             wwe: wwe, fwe: fwe, tag: tag};
  endfunction

  bit done = 0;

  initial begin
    in_valid = 0; op_i = 0; src_lit_i = 0; dest_f_i = 0; bit_idx_i = 0;
    w_i = 0; f_i = 0; lit_i = 0; carry_i = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R10 reset");
    rst = 1'b0;

    // directed boundary examples, hand-computed
    send_x(1, 1, 0, 0, 8'h10, 8'h00, 8'h15, 0, mk(8'h25, 0, 0, 0, 1, 1, 1, 1, 0, "R1 add lit"));
    send_x(1, 0, 1, 0, 8'h08, 8'hF8, 8'h00, 0, mk(8'h00, 1, 1, 1, 1, 1, 1, 0, 1, "R1 add wrap"));
    send_x(2, 1, 1, 0, 8'h04, 8'h00, 8'h03, 0, mk(8'hFF, 0, 0, 0, 1, 1, 1, 1, 0, "R2 sub borrow"));
    send_x(2, 0, 0, 0, 8'h0F, 8'h20, 8'h00, 0, mk(8'h11, 1, 0, 0, 1, 1, 1, 1, 0, "R2 sub nibble"));
    send_x(7, 0, 1, 0, 8'h00, 8'hFF, 8'h00, 0, mk(8'h00, 0, 0, 1, 0, 0, 1, 0, 1, "R3 inc wrap"));
    send_x(8, 0, 0, 0, 8'h00, 8'h01, 8'h00, 1, mk(8'h00, 0, 0, 1, 0, 0, 1, 1, 0, "R3 dec to zero"));
    send_x(9, 0, 0, 0, 8'h00, 8'hE6, 8'h00, 0, mk(8'hCC, 1, 0, 0, 1, 0, 0, 1, 0, "R4 rol"));
    send_x(10, 0, 1, 0, 8'h00, 8'h01, 8'h00, 1, mk(8'h80, 1, 0, 0, 1, 0, 0, 0, 1, "R4 ror"));
    send_x(11, 0, 0, 0, 8'h00, 8'hF3, 8'h00, 0, mk(8'h3F, 0, 0, 0, 0, 0, 0, 1, 0, "R5 swap"));
    send_x(13, 0, 1, 0, 8'h17, 8'h00, 8'h00, 0, mk(8'h00, 0, 0, 1, 0, 0, 1, 0, 1, "R6 movf to f"));
    send_x(14, 0, 0, 0, 8'h40, 8'h20, 8'h00, 0, mk(8'h40, 0, 0, 0, 0, 0, 0, 0, 1, "R6 w to f"));
    send_x(12, 0, 0, 0, 8'h55, 8'h33, 8'h00, 1, mk(8'h00, 0, 0, 1, 0, 0, 1, 1, 0, "R7 clear w"));
    send_x(16, 0, 0, 7, 8'h00, 8'hC7, 8'h00, 0, mk(8'h47, 0, 0, 0, 0, 0, 0, 0, 1, "R8 bit clear"));
    send_x(15, 0, 0, 3, 8'h00, 8'h20, 8'h00, 0, mk(8'h28, 0, 0, 0, 0, 0, 0, 0, 1, "R8 bit set"));
    send_x(0, 0, 1, 0, 8'h10, 8'h00, 8'h5A, 1, mk(8'h5A, 0, 0, 0, 0, 0, 0, 1, 0, "R9 load const"));
    send_x(20, 0, 1, 0, 8'h10, 8'h22, 8'h33, 1, mk(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R12 unused op"));

    // R11: idle cycles carrying a clear op must produce nothing
    idle(2);
    @(negedge clk);
    check_quiet("R11 idle");

    // exhaustive operand sweep, op and modes spread across pairs
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int  op;
        op = (a * 7 + b) % 17;
        send(op, bit'((a >> 1) ^ b), bit'(a ^ (b >> 2)), (b + a) % 8,
             a, b, b ^ 8'h5A, bit'((a >> 3) ^ (b >> 7)));
      end
    end
    idle(3);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d results missing expected 0", sb_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10: watchdog expired expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule